// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Engine

This block moves outgoing packets from memory to a byte stream. Software lays out a circular chain of 16-byte descriptors in memory. Each descriptor holds a buffer address at byte offset +0, a control word at +4, the address of the following descriptor at +8, and an unused word at +12. Software hands a descriptor to the engine by clearing the ownership flag (control bit 31). The engine then reads the descriptor and streams its buffer out byte by byte. After the last byte has been accepted, it writes the control word back with bit 31 set. It then follows the link to the next descriptor. A packet may span several descriptors: control bit 24 says that the packet continues in the next one, and control bits 11:0 give the byte count.

When the engine meets a descriptor that it does not own, it raises an underrun flag and switches itself off. It stays off until software clears the flag and enables it again. A failed memory access raises a bus-error flag and also halts the engine. Every finished packet adds one to an 8-bit saturating counter. Software acknowledges packets one at a time by writing 1 to the packet-sent bit. The interrupt line is the OR of the status flags that the mask lets through.

The walker is a seven-state machine:
- `W_IDLE` moves to `W_RD_CTL` while enabled.
- `W_RD_CTL` goes to `W_RD_BUF` on an owned descriptor. It goes to `W_IDLE` on underrun or error.
- `W_RD_BUF` goes to `W_RD_LINK`.
- `W_RD_LINK` goes to `W_RD_WORD`, or to `W_WR_BACK` when the length is zero.
- `W_RD_WORD` goes to `W_SEND`.
- `W_SEND` returns to `W_RD_WORD` at each word boundary. It goes to `W_WR_BACK` after the final byte.
- `W_WR_BACK` goes to `W_RD_CTL` while enabled, else to `W_IDLE`.
- Any memory error sends every read or write state to `W_IDLE`.

Top module: `txdma_tx_engine`

## Requirements
- R1: After reset, every register reads 0: control (address 0), descriptor pointer (1), status (2), mask (3) and pending (4). `irq`, `tx_valid` and `mem_req` are low.
- R2: The engine reads a descriptor as buffer address at +0, control at +4 and next link at +8. It never rewrites a descriptor whose control bit 31 was set when it was read.
- R3: Bytes leave in ascending address order, starting at the buffer byte address. Within a word, lane 0 holds bits 7:0. Exactly control[11:0] bytes are sent per descriptor. `tx_last` marks the final byte of a descriptor whose control bit 24 is clear.
- R4: The control word is written back with bit 31 set, all other bits unchanged. This happens only after the final byte has been taken with `tx_valid` and `tx_ready` both high.
- R5: Reading a control word with bit 31 set raises status bit 1 (underrun) and clears control bit 0 (enable). The descriptor pointer stays on that descriptor.
- R6: While status bit 1 or bit 3 is set, writing 1 to enable is ignored. Writing 1 to either bit clears it. A later enable resumes at the current descriptor pointer.
- R7: Status bits 23:16 count completed packets. The count rises by one after the write-back of each descriptor with control bit 24 clear. Status bit 0 reads 1 exactly while the count is nonzero.
- R8: Writing 1 to status bit 0 lowers the count by one and has no effect at zero. The count saturates at 255.
- R9: A write to the descriptor pointer takes effect only while enable is 0 and the engine is idle. Reading the pointer returns the current descriptor address.
- R10: A memory access answered with `mem_err` sets status bit 3 (bus error), clears enable and stops the engine.
- R11: The mask (register 3) keeps bits 0, 1 and 3. Pending (register 4) is the status bits 0, 1 and 3 ANDed with the mask. `irq` is the OR of the pending bits.
- R12: Clearing enable while a descriptor is in flight lets that descriptor finish and be written back. The engine then idles with the pointer on the next descriptor.
- R13: A memory request holds its address and direction until `mem_ack`. A presented byte holds its data and `tx_last` until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Access failed, valid with `mem_ack` |
| tx_data | output | 8 | Streamed byte |
| tx_valid | output | 1 | Byte present |
| tx_last | output | 1 | Final byte of a packet |
| tx_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
Register writes take effect at the clock edge that ends the write strobe. Register reads are combinational, so the bench checks a flag or count one cycle after the event that set it, sampled at the falling edge. Descriptor work is not tied to a fixed latency: each memory access costs two cycles in the bench memory, and random back-pressure stretches streaming. So the bench polls the enable bit with a bound and compares the full byte stream and status only after the engine has stopped. For write-back ordering and in-flight stop, the bench freezes `tx_ready` or removes enable at a known point. It then reads the descriptor words in memory before and after release.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    // descriptor control word fields
    localparam int unsigned OWN_BIT  = 31;
    localparam int unsigned CONT_BIT = 24;

    // status / pending bit positions
    localparam int unsigned SB_SENT  = 0;
    localparam int unsigned SB_UNDR  = 1;
    localparam int unsigned SB_BERR  = 3;
    localparam int unsigned CNT_LSB  = 16;

    // register word indices
    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_DESC = 3'd1;
    localparam logic [2:0] RA_STAT = 3'd2;
    localparam logic [2:0] RA_MASK = 3'd3;
    localparam logic [2:0] RA_PEND = 3'd4;

    localparam logic [3:0] IRQ_BITS = 4'b1011;

    typedef enum logic [2:0] {
        W_IDLE,
        W_RD_CTL,
        W_RD_BUF,
        W_RD_LINK,
        W_RD_WORD,
        W_SEND,
        W_WR_BACK
    } walk_state_e;

endpackage

// File: rtl/txdma_walker.sv
module txdma_walker
    import txdma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          base_load,
    input  logic [AW-1:0] base_val,
    output logic [AW-1:0] cur_ptr,
    output logic          idle,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic [7:0]    tx_data,
    output logic          tx_valid,
    output logic          tx_last,
    input  logic          tx_ready,
    output logic          pkt_done,
    output logic          underrun_evt,
    output logic          buserr_evt
);

    localparam logic [AW-1:0] OFS_CTL  = AW'(4);
    localparam logic [AW-1:0] OFS_LINK = AW'(8);
    localparam logic [LW-1:0] ONE_LEFT = LW'(1);

    walk_state_e   st_q, st_d;
    logic [AW-1:0] cur_q, buf_q, link_q;
    logic [31:0]   ctl_q, word_q;
    logic [LW-1:0] left_q;
    logic          ack_ok;

    assign ack_ok = mem_ack && !mem_err;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= W_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            W_IDLE:    if (run) st_d = W_RD_CTL;
            W_RD_CTL:  if (mem_ack)
                           st_d = (mem_err || mem_rdata[OWN_BIT]) ? W_IDLE : W_RD_BUF;
            W_RD_BUF:  if (mem_ack) st_d = mem_err ? W_IDLE : W_RD_LINK;
            W_RD_LINK: if (mem_ack)
                           st_d = mem_err ? W_IDLE :
                                  (left_q == '0) ? W_WR_BACK : W_RD_WORD;
            W_RD_WORD: if (mem_ack) st_d = mem_err ? W_IDLE : W_SEND;
            W_SEND:    if (tx_ready)
                           st_d = (left_q == ONE_LEFT) ? W_WR_BACK :
                                  (buf_q[1:0] == 2'b11) ? W_RD_WORD : W_SEND;
            W_WR_BACK: if (mem_ack)
                           st_d = (mem_err || !run) ? W_IDLE : W_RD_CTL;
            default:   st_d = W_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            buf_q  <= '0;
            link_q <= '0;
            ctl_q  <= '0;
            word_q <= '0;
            left_q <= '0;
        end else begin
            if (st_q == W_IDLE && base_load) cur_q <= base_val;
            if (st_q == W_RD_CTL && ack_ok && !mem_rdata[OWN_BIT]) begin
                ctl_q  <= mem_rdata;
                left_q <= mem_rdata[LW-1:0];
            end
            if (st_q == W_RD_BUF  && ack_ok) buf_q  <= mem_rdata[AW-1:0];
            if (st_q == W_RD_LINK && ack_ok) link_q <= mem_rdata[AW-1:0];
            if (st_q == W_RD_WORD && ack_ok) word_q <= mem_rdata;
            if (st_q == W_SEND && tx_ready) begin
                buf_q  <= buf_q + AW'(1);
                left_q <= left_q - ONE_LEFT;
            end
            if (st_q == W_WR_BACK && ack_ok) cur_q <= link_q;
        end
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        unique case (st_q)
            W_RD_CTL:  begin mem_req = 1'b1; mem_addr = cur_q + OFS_CTL;  end
            W_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur_q;            end
            W_RD_LINK: begin mem_req = 1'b1; mem_addr = cur_q + OFS_LINK; end
            W_RD_WORD: begin mem_req = 1'b1; mem_addr = {buf_q[AW-1:2], 2'b00}; end
            W_WR_BACK: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = cur_q + OFS_CTL; end
            default:   ;
        endcase
    end

    assign mem_wdata    = ctl_q | (32'd1 << OWN_BIT);
    assign tx_valid     = (st_q == W_SEND);
    assign tx_data      = word_q[{buf_q[1:0], 3'b000} +: 8];
    assign tx_last      = tx_valid && (left_q == ONE_LEFT) && !ctl_q[CONT_BIT];
    assign underrun_evt = (st_q == W_RD_CTL) && ack_ok && mem_rdata[OWN_BIT];
    assign buserr_evt   = mem_req && mem_ack && mem_err;
    assign pkt_done     = (st_q == W_WR_BACK) && ack_ok && !ctl_q[CONT_BIT];
    assign idle         = (st_q == W_IDLE);
    assign cur_ptr      = cur_q;

endmodule

// File: rtl/txdma_csr.sv
module txdma_csr
    import txdma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [AW-1:0]    cur_ptr,
    input  logic             walker_idle,
    input  logic             pkt_done,
    input  logic             underrun_evt,
    input  logic             buserr_evt,
    output logic             run,
    output logic             base_load,
    output logic [AW-1:0]    base_val,
    output logic             undr_flag,
    output logic [CNT_W-1:0] pkt_cnt,
    output logic             irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             en_q, undr_q, berr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       mask_q;
    logic             wr_ctrl, wr_desc, wr_stat, wr_mask;
    logic             inc, dec;
    logic [3:0]       flags, pend;

    assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
    assign wr_desc = reg_wr && (reg_addr == RA_DESC);
    assign wr_stat = reg_wr && (reg_addr == RA_STAT);
    assign wr_mask = reg_wr && (reg_addr == RA_MASK);

    assign inc = pkt_done;
    assign dec = wr_stat && reg_wdata[SB_SENT] && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            undr_q <= 1'b0;
            berr_q <= 1'b0;
            cnt_q  <= '0;
            mask_q <= '0;
        end else begin
            if (underrun_evt || buserr_evt)
                en_q <= 1'b0;
            else if (wr_ctrl)
                en_q <= reg_wdata[0] && !undr_q && !berr_q;

            if (underrun_evt)
                undr_q <= 1'b1;
            else if (wr_stat && reg_wdata[SB_UNDR])
                undr_q <= 1'b0;

            if (buserr_evt)
                berr_q <= 1'b1;
            else if (wr_stat && reg_wdata[SB_BERR])
                berr_q <= 1'b0;

            if (inc && !dec && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + CNT_W'(1);
            else if (dec && !inc)
                cnt_q <= cnt_q - CNT_W'(1);

            if (wr_mask) mask_q <= reg_wdata[3:0] & IRQ_BITS;
        end
    end

    assign flags = {berr_q, 1'b0, undr_q, (cnt_q != '0)};
    assign pend  = flags & mask_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: reg_rdata[0] = en_q;
            RA_DESC: reg_rdata = 32'(cur_ptr);
            RA_STAT: begin
                reg_rdata[3:0] = flags;
                reg_rdata[CNT_LSB +: CNT_W] = cnt_q;
            end
            RA_MASK: reg_rdata[3:0] = mask_q;
            RA_PEND: reg_rdata[3:0] = pend;
            default: ;
        endcase
    end

    assign run       = en_q;
    assign base_load = wr_desc && !en_q && walker_idle;
    assign base_val  = reg_wdata[AW-1:0];
    assign undr_flag = undr_q;
    assign pkt_cnt   = cnt_q;
    assign irq       = |pend;

endmodule

// File: rtl/txdma_tx_engine.sv
module txdma_tx_engine
    import txdma_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned LW    = 12,
    parameter int unsigned CNT_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic [7:0]    tx_data,
    output logic          tx_valid,
    output logic          tx_last,
    input  logic          tx_ready,
    output logic          irq
);

    logic             run_w, base_load_w, idle_w;
    logic [AW-1:0]    base_w, cur_w;
    logic             done_w, undr_evt_w, berr_evt_w;
    logic             undr_w;
    logic [CNT_W-1:0] cnt_w;

    txdma_csr #(.AW(AW), .CNT_W(CNT_W)) u_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .cur_ptr      (cur_w),
        .walker_idle  (idle_w),
        .pkt_done     (done_w),
        .underrun_evt (undr_evt_w),
        .buserr_evt   (berr_evt_w),
        .run          (run_w),
        .base_load    (base_load_w),
        .base_val     (base_w),
        .undr_flag    (undr_w),
        .pkt_cnt      (cnt_w),
        .irq          (irq)
    );

    txdma_walker #(.AW(AW), .LW(LW)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run_w),
        .base_load    (base_load_w),
        .base_val     (base_w),
        .cur_ptr      (cur_w),
        .idle         (idle_w),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata),
        .mem_ack      (mem_ack),
        .mem_err      (mem_err),
        .tx_data      (tx_data),
        .tx_valid     (tx_valid),
        .tx_last      (tx_last),
        .tx_ready     (tx_ready),
        .pkt_done     (done_w),
        .underrun_evt (undr_evt_w),
        .buserr_evt   (berr_evt_w)
    );

endmodule

// File: rtl/txdma_tx_engine_chk.sv
module txdma_tx_engine_chk #(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack,
    input logic [7:0]       tx_data,
    input logic             tx_valid,
    input logic             tx_last,
    input logic             tx_ready,
    input logic             run,
    input logic             undr,
    input logic [CNT_W-1:0] cnt
);

    // R13: request held until acknowledged
    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R13: presented byte held under back-pressure
    assert_byte_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    // R4: every write-back returns ownership
    assert_wb_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[31]);

    // R5: underrun keeps the engine off
    assert_undr_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        undr |-> !run);

    // R7: the counter moves by at most one per cycle
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1)) ||
        (cnt == $past(cnt) - CNT_W'(1)));

    // R3: no byte is offered while memory is busy
    assert_send_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && mem_req));

endmodule

bind txdma_tx_engine txdma_tx_engine_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready),
    .run       (run_w),
    .undr      (undr_w),
    .cnt       (cnt_w)
);

// File: tb/test_txdma_tx_engine.sv
`timescale 1ns/1ps
module test_txdma_tx_engine;

    localparam logic [2:0] A_CTRL = 3'd0, A_DESC = 3'd1, A_STAT = 3'd2,
                           A_MASK = 3'd3, A_PEND = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_last;
    logic        tx_ready = 1'b0;
    logic        irq;

    txdma_tx_engine i_txdma_tx_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
        .tx_ready(tx_ready), .irq(irq)
    );

    logic [31:0] mem [0:2047];
    int checks = 0;
    int errors = 0;
    int ready_mode = 0;
    int exp_cnt = 0;
    bit done_flag = 0;
    logic [7:0] exp_b[$], got_b[$];
    bit         exp_l[$], got_l[$];

    initial forever #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // memory model: one wait cycle, error above 2 GB
    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                mem_ack = 1'b1;
                mem_err = mem_addr[31];
                if (!mem_addr[31]) begin
                    if (mem_we) mem[mem_addr[12:2]] = mem_wdata;
                    mem_rdata = mem[mem_addr[12:2]];
                end else mem_rdata = '0;
            end else begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end
        end
    end

    // stream sink and hold check
    initial begin
        bit stall = 0;
        logic [7:0] pd = '0;
        bit pl = 0;
        forever begin
            @(negedge clk);
            if (stall) chk(tx_valid && tx_data == pd && tx_last == pl,
                           "R13 byte held", {23'd0, tx_valid, tx_data}, {24'd1, pd});
            tx_ready = (ready_mode == 1) ? 1'b1 : (ready_mode == 2) ? 1'b0 : ($urandom % 4 != 0);
            if (tx_valid && tx_ready) begin
                got_b.push_back(tx_data);
                got_l.push_back(tx_last);
            end
            stall = tx_valid && !tx_ready;
            pd = tx_data;
            pl = tx_last;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input int lim);
        logic [31:0] d;
        for (int i = 0; i < lim; i++) begin
            rd(A_CTRL, d);
            if (!d[0]) return;
        end
        chk(0, "R5 engine stop", 32'd1, 32'd0);
    endtask

    task automatic set_byte(input logic [31:0] a, input logic [7:0] v);
        mem[a[12:2]][{a[1:0], 3'b000} +: 8] = v;
    endtask

    task automatic put_desc(input logic [31:0] d, input logic [31:0] ba, input logic [31:0] ctl, input logic [31:0] nx);
        mem[d[12:2]] = ba;
        mem[d[12:2] + 11'd1] = ctl;
        mem[d[12:2] + 11'd2] = nx;
        mem[d[12:2] + 11'd3] = '0;
    endtask

    function automatic int sat(input int v);
        return (v > 255) ? 255 : v;
    endfunction

    // n owned descriptors then one not owned, closed into a ring
    task automatic build_chain(input logic [31:0] db, input int n, input int maxlen, output int pkts);
        pkts = 0;
        for (int i = 0; i < n; i++) begin
            int len = 1 + ($urandom % maxlen);
            logic [31:0] ba = 32'h1800 + i * 32'h80 + ($urandom % 4);
            bit more = (i == n - 1) ? 1'b0 : (i == 0 && n > 2) ? 1'b1 : 1'($urandom % 2);
            for (int b = 0; b < len; b++) begin
                logic [7:0] v = 8'($urandom);
                set_byte(ba + b, v);
                exp_b.push_back(v);
                exp_l.push_back(!more && b == len - 1);
            end
            if (!more) pkts++;
            put_desc(db + i * 16, ba, {7'd0, more, 12'd0, 12'(len)}, db + (i + 1) * 16);
        end
        put_desc(db + n * 16, 32'h0, 32'h8000_0000, db);
    endtask

    task automatic cmp_stream(input string req);
        chk(got_b.size() == exp_b.size(), req, got_b.size(), exp_b.size());
        for (int i = 0; i < exp_b.size() && i < got_b.size(); i++)
            chk(got_b[i] == exp_b[i] && got_l[i] == exp_l[i], req,
                {23'd0, got_l[i], got_b[i]}, {23'd0, exp_l[i], exp_b[i]});
        exp_b.delete(); exp_l.delete(); got_b.delete(); got_l.delete();
    endtask

    task automatic drain();
        logic [31:0] d;
        for (int i = 0; i < 300; i++) begin
            rd(A_STAT, d);
            if (d[23:16] == 0) break;
            wr(A_STAT, 32'h1);
        end
        rd(A_STAT, d);
        chk(d[23:16] == 0 && !d[0], "R8 drain to zero", d, 32'd0);
        exp_cnt = 0;
    endtask

    initial begin
        logic [31:0] d, p;
        int pk;
        ready_mode = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, d); chk(d == 0, "R1 ctrl", d, 0);
        rd(A_DESC, d); chk(d == 0, "R1 desc", d, 0);
        rd(A_STAT, d); chk(d == 0, "R1 status", d, 0);
        rd(A_MASK, d); chk(d == 0, "R1 mask", d, 0);
        rd(A_PEND, d); chk(d == 0, "R1 pending", d, 0);
        chk(!irq && !tx_valid && !mem_req, "R1 outputs", {irq, tx_valid, mem_req}, 0);

        // R2 R3 R5 R7: ring of five, one multi-descriptor packet
        build_chain(32'h1100, 5, 40, pk);
        wr(A_DESC, 32'h1100);
        wr(A_CTRL, 1);
        wait_idle(3000);
        cmp_stream("R3 stream");
        exp_cnt = sat(exp_cnt + pk);
        rd(A_STAT, d);
        chk(d[1], "R5 underrun flag", d, 32'h2);
        chk(d[23:16] == exp_cnt && d[0], "R7 count", d[23:16], exp_cnt);
        rd(A_DESC, d); chk(d == 32'h1150, "R5 pointer on unowned", d, 32'h1150);
        for (int i = 0; i < 5; i++)
            chk(mem[(32'h1104 + i * 16) >> 2][31], "R4 ownership returned", mem[(32'h1104 + i * 16) >> 2], 32'h8000_0000);
        chk(mem[32'h1154 >> 2] == 32'h8000_0000, "R2 unowned untouched", mem[32'h1154 >> 2], 32'h8000_0000);

        // R11 masking
        wr(A_MASK, 32'h0); chk(!irq, "R11 all masked", irq, 0);
        wr(A_MASK, 32'h2); rd(A_PEND, d);
        chk(irq && d == 32'h2, "R11 underrun pending", {irq, d[30:0]}, 32'h8000_0002);
        wr(A_MASK, 32'hF); rd(A_MASK, d); chk(d == 32'hB, "R11 mask bits", d, 32'hB);
        wr(A_MASK, 32'h8); chk(!irq, "R11 bus error masked only", irq, 0);

        // R6 enable ignored while underrun
        wr(A_CTRL, 1); rd(A_CTRL, d); chk(d == 0, "R6 enable ignored", d, 0);
        repeat (20) @(negedge clk);
        chk(got_b.size() == 0, "R6 no bytes", got_b.size(), 0);

        // R6 resume at current descriptor
        for (int b = 0; b < 7; b++) begin
            set_byte(32'h1A80 + b, 8'(b + 8'h30));
            exp_b.push_back(8'(b + 8'h30)); exp_l.push_back(b == 6);
        end
        put_desc(32'h1150, 32'h1A80, 32'd7, 32'h1100);
        wr(A_STAT, 32'h2);
        rd(A_STAT, d); chk(!d[1], "R6 underrun cleared", d, 0);
        wr(A_CTRL, 1);
        wait_idle(1000);
        cmp_stream("R6 resumed stream");
        exp_cnt = sat(exp_cnt + 1);
        rd(A_DESC, d); chk(d == 32'h1100, "R6 pointer", d, 32'h1100);

        // R8 acknowledge decrement
        rd(A_STAT, p);
        wr(A_STAT, 32'h1);
        rd(A_STAT, d);
        chk(d[23:16] == p[23:16] - 1, "R8 decrement", d[23:16], p[23:16] - 1);
        drain();
        rd(A_STAT, d); chk(!d[0], "R7 sent bit low at zero", d, 0);
        wr(A_STAT, 32'h1); rd(A_STAT, d);
        chk(d[23:16] == 0, "R8 no underflow", d[23:16], 0);

        // R8 saturation and R9 ignored pointer write
        ready_mode = 1;
        set_byte(32'h17F0, 8'h5A);
        for (int i = 0; i < 260; i++) begin
            put_desc(i * 16, 32'h17F0, 32'd1, (i + 1) * 16);
            exp_b.push_back(8'h5A); exp_l.push_back(1'b1);
        end
        put_desc(260 * 16, 0, 32'h8000_0000, 0);
        wr(A_STAT, 32'h2);
        wr(A_DESC, 32'h0);
        wr(A_CTRL, 1);
        repeat (50) @(negedge clk);
        wr(A_DESC, 32'h1234);
        wait_idle(20000);
        rd(A_DESC, d); chk(d == 32'h1040, "R9 write while running ignored", d, 32'h1040);
        rd(A_STAT, d); chk(d[23:16] == 255, "R8 saturate", d[23:16], 255);
        cmp_stream("R3 long chain");
        drain();

        // R4 write-back waits for final handshake
        ready_mode = 2;
        set_byte(32'h1800, 8'hA1); set_byte(32'h1801, 8'hB2);
        exp_b.push_back(8'hA1); exp_l.push_back(0);
        exp_b.push_back(8'hB2); exp_l.push_back(1);
        put_desc(32'h1180, 32'h1800, 32'd2, 32'h1190);
        put_desc(32'h1190, 0, 32'h8000_0000, 32'h1180);
        wr(A_STAT, 32'h2);
        wr(A_DESC, 32'h1180);
        rd(A_DESC, d); chk(d == 32'h1180, "R9 pointer load", d, 32'h1180);
        wr(A_CTRL, 1);
        repeat (30) @(negedge clk);
        chk(tx_valid && !tx_last, "R4 byte waiting", {tx_valid, tx_last}, 2'b10);
        chk(!mem[32'h1184 >> 2][31], "R4 no early write-back", mem[32'h1184 >> 2], 32'd2);
        ready_mode = 1;
        wait_idle(500);
        chk(mem[32'h1184 >> 2] == 32'h8000_0002, "R4 write-back", mem[32'h1184 >> 2], 32'h8000_0002);
        cmp_stream("R4 stream");
        exp_cnt = 1;

        // R12 stop at descriptor boundary
        ready_mode = 0;
        for (int b = 0; b < 30; b++) begin
            set_byte(32'h1880 + b, 8'(b));
            exp_b.push_back(8'(b)); exp_l.push_back(b == 29);
        end
        put_desc(32'h11A0, 32'h1880, 32'd30, 32'h11B0);
        put_desc(32'h11B0, 32'h1900, 32'd5, 32'h11C0);
        put_desc(32'h11C0, 0, 32'h8000_0000, 32'h11A0);
        wr(A_STAT, 32'h2);
        wr(A_DESC, 32'h11A0);
        wr(A_CTRL, 1);
        for (int i = 0; i < 200 && !tx_valid; i++) @(negedge clk);
        wr(A_CTRL, 0);
        repeat (300) @(negedge clk);
        rd(A_DESC, d); chk(d == 32'h11B0, "R12 pointer after stop", d, 32'h11B0);
        rd(A_STAT, d); chk(!d[1], "R12 no underrun", d, 0);
        chk(mem[32'h11A4 >> 2][31] && !mem[32'h11B4 >> 2][31], "R12 one descriptor done",
            {mem[32'h11A4 >> 2][31], mem[32'h11B4 >> 2][31]}, 2'b10);
        cmp_stream("R12 stream");
        exp_cnt = 2;

        // R10 bus error
        put_desc(32'h11D0, 32'h8000_0000, 32'd4, 32'h11E0);
        wr(A_DESC, 32'h11D0);
        wr(A_CTRL, 1);
        wait_idle(500);
        rd(A_STAT, d); chk(d[3], "R10 bus error flag", d, 32'h8);
        chk(irq, "R11 bus error irq", irq, 1);
        rd(A_DESC, d); chk(d == 32'h11D0, "R10 stopped on descriptor", d, 32'h11D0);
        wr(A_CTRL, 1); rd(A_CTRL, d); chk(d == 0, "R6 enable ignored on bus error", d, 0);
        wr(A_STAT, 32'h8); rd(A_STAT, d); chk(!d[3], "R6 bus error cleared", d, 0);
        cmp_stream("R10 no bytes");
        drain();

        // R3 R7 random rings
        for (int r = 0; r < 4; r++) begin
            build_chain(32'h1200, 2 + ($urandom % 6), 60, pk);
            wr(A_STAT, 32'h2);
            wr(A_DESC, 32'h1200);
            wr(A_CTRL, 1);
            wait_idle(5000);
            cmp_stream("R3 random stream");
            exp_cnt = sat(exp_cnt + pk);
            rd(A_STAT, d);
            chk(d[23:16] == exp_cnt, "R7 random count", d[23:16], exp_cnt);
        end

        finish_run();
    end

endmodule